// File: doc/BRIEF.md
# Voice Pitch Stepper and Stereo Mixer

This block runs the playback side of a 24-voice sample player. Each voice has a fixed-point play position with 12 fractional bits. The position points into a decoded block of 28 samples, and a 16-bit pitch word is added to it once per output sample. When the position runs past the end of the block, the block asks an external block decoder for the next block. It reads the flag byte of that block's header to latch a loop point, restart from that point, or retire the voice. It can also raise an interrupt when a watched RAM address lies inside the block being fetched.

The voices are served one after another within each output sample period. For every voice, the block decodes the voice's left and right volume words into signed gains. It scales the sample that the decoder holds for the current position, and adds the result into two saturating 16-bit accumulators. After the last voice, the stereo pair is presented with a one-cycle valid strobe. Software writes per-voice volume, pitch and start address through a small write port. A keying strobe with a voice mask starts or restarts any set of voices.

Top module: `voice_step_mixer`

## Requirements
- R1: After reset, `out_l` and `out_r` read 0, `sample_valid`, `fetch_req` and `irq_hit` are low, and every voice is inactive with position 0.
- R2: The play position has 12 fractional bits. Once per output sample, the voice's pitch word is added to it after mixing, and the sample read is the one at index `position >> 12`, shown on `samp_idx`.
- R3: When an active voice's position is at or above 28<<12, the block raises `fetch_req` with the voice's halfword block address and holds both until `fetch_done`. It then advances the block address by 8 halfwords modulo the RAM size and subtracts 28<<12 from the position, so that the carry is kept.
- R4: Keying a voice on sets its block address to start*4 modulo the RAM size and its position to 28<<12, and marks it active. It flags that voice's next fetch with `fetch_first` so that the decoder clears its prediction history.
- R5: A fetched header whose flag bit 2 is set makes that block's address the voice's loop address.
- R6: If flag bit 0 is set, a flag byte of exactly 3 sends the voice back to its loop address. Any other value retires the voice. A retired voice plays out its current block, and is then neither fetched nor mixed.
- R7: `irq_hit` pulses for one cycle, together with the fetch, when `irq_en` is high and `irq_addr`*4 lies within the block address through the block address + 7.
- R8: Volume word decoding: if bit 15 is set, the gain is bits 6:0 times 0x80. Otherwise, if bit 14 is set, the gain is minus bits 13:0. Otherwise, the gain is the word itself.
- R9: Each voice adds sample*gain/0x4000, truncated toward zero, to each channel. Voices are taken in order 0 to 23, and the running sum is clamped to -32768..32767 after every addition.
- R10: `sample_valid` is a one-cycle pulse after all 24 voices of a period have been mixed. `out_l` and `out_r` hold that result until the next period completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Per-voice configuration write strobe |
| cfg_voice | input | 5 | Voice index for the write |
| cfg_field | input | 2 | 0 left volume, 1 right volume, 2 pitch, 3 start address |
| cfg_data | input | 16 | Write data |
| key_stb | input | 1 | Key-on strobe |
| key_mask | input | 24 | Voices to key on |
| irq_en | input | 1 | Enables the address-match interrupt |
| irq_addr | input | 16 | Watched address in units of 4 halfwords |
| sample_start | input | 1 | Starts one output sample period (accepted when idle) |
| fetch_req | output | 1 | Block fetch request to the decoder |
| fetch_voice | output | 5 | Voice being fetched |
| fetch_addr | output | 18 | Halfword address of the block header |
| fetch_first | output | 1 | First fetch since key-on: the decoder clears its history |
| fetch_done | input | 1 | Decoder has decoded the block |
| fetch_flags | input | 8 | Header flag byte of the fetched block |
| samp_voice | output | 5 | Voice whose decoded sample is read |
| samp_idx | output | 5 | Sample index inside the decoded block |
| samp_data | input | 16 | Signed decoded sample at that index |
| out_l | output | 16 | Signed left mix |
| out_r | output | 16 | Signed right mix |
| sample_valid | output | 1 | Mix result valid pulse |
| irq_hit | output | 1 | Address-match interrupt pulse |

## Verification
The mix is tried with address-hashed samples at integer, fractional and maximum pitch. These patterns separate wrong index selection, a lost carry on block wrap, and a block address that fails to wrap at the top of RAM. Header flag patterns for plain end, loop-start-then-loop and no flag distinguish retirement, reload from the latched loop point and plain advance. Constant full-scale samples with gains of opposite sign show whether the clamp is applied after each voice or only once at the end. The watched address is placed inside one block and then disabled, which separates a correct window match from one that is off by a block or that ignores the enable.

// File: rtl/vm_pkg.sv
package vm_pkg;
    // Sample and gain format shared by the mixing lanes.
    localparam int SMP_W      = 16;
    localparam int GAIN_SHIFT = 14;

    // Configuration field selector on the write port.
    typedef enum logic [1:0] {
        FLD_GAIN_L = 2'd0,
        FLD_GAIN_R = 2'd1,
        FLD_STEP   = 2'd2,
        FLD_BASE   = 2'd3
    } cfg_field_e;

    // Voice sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FETCH = 2'd2,
        ST_MIX   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/vm_gain_decode.sv
// Turns a 16-bit volume word into a signed gain.
// Bit 15 set: small positive gain from bits 6:0 scaled by 0x80.
// Bit 14 set: negative gain from bits 13:0. Otherwise the word itself.
// Assumes nothing about the word; purely combinational.
module vm_gain_decode (
    input  logic [15:0]        vol_word,
    output logic signed [15:0] gain
);
    // Priority decode of the two mode bits.
    always_comb begin
        if (vol_word[15]) begin
            gain = $signed({2'b00, vol_word[6:0], 7'b000_0000});
        end else if (vol_word[14]) begin
            gain = -$signed({2'b00, vol_word[13:0]});
        end else begin
            gain = $signed(vol_word);
        end
    end
endmodule

// File: rtl/vm_mix_lane.sv
// One stereo channel of the mixer: decodes the volume word, scales the
// sample by gain/2^GAIN_SHIFT with truncation toward zero and adds the
// result to the running sum, clamped to the signed sample range.
// Assumes the sum input is already within the signed sample range.
module vm_mix_lane
    import vm_pkg::*;
(
    input  logic [15:0]             vol_word,
    input  logic signed [SMP_W-1:0] sample,
    input  logic signed [SMP_W-1:0] acc_in,
    output logic signed [SMP_W-1:0] acc_out
);
    localparam int PW = 2 * SMP_W;
    localparam int QW = PW - GAIN_SHIFT;
    localparam logic signed [SMP_W+2:0] POS_MAX = (SMP_W+3)'((1 << (SMP_W-1)) - 1);
    localparam logic signed [SMP_W+2:0] NEG_MIN = -(SMP_W+3)'(1 << (SMP_W-1));

    logic signed [15:0]      gain;
    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    biased;
    logic signed [QW-1:0]    scaled;
    logic signed [SMP_W+2:0] total;

    vm_gain_decode u_gain (
        .vol_word (vol_word),
        .gain     (gain)
    );

    // Scale with round-toward-zero, then add and clamp.
    always_comb begin
        prod   = sample * gain;
        biased = prod + (prod[PW-1] ? PW'((1 << GAIN_SHIFT) - 1) : PW'(0));
        scaled = $signed(biased[PW-1:GAIN_SHIFT]);
        total  = (SMP_W+3)'(acc_in) + (SMP_W+3)'(scaled);
        if (total > POS_MAX) begin
            acc_out = POS_MAX[SMP_W-1:0];
        end else if (total < NEG_MIN) begin
            acc_out = NEG_MIN[SMP_W-1:0];
        end else begin
            acc_out = total[SMP_W-1:0];
        end
    end
endmodule

// File: rtl/vm_voice_cfg.sv
// Per-voice configuration store: left/right volume words, pitch word and
// start address. Written one field at a time; the selected voice's volume
// and pitch are read out for the sequencer, all start addresses in parallel
// for keying. Assumes writes to voice indices past NV are dropped.
module vm_voice_cfg
    import vm_pkg::*;
#(
    parameter int NV  = 24,
    parameter int VIW = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [VIW-1:0]        wr_voice,
    input  logic [1:0]            wr_field,
    input  logic [15:0]           wr_data,
    input  logic [VIW-1:0]        rd_voice,
    output logic [15:0]           rd_gain_l,
    output logic [15:0]           rd_gain_r,
    output logic [15:0]           rd_step,
    output logic [NV-1:0][15:0]   base_all
);
    logic [15:0] gl_q   [NV];
    logic [15:0] gr_q   [NV];
    logic [15:0] step_q [NV];
    logic [15:0] base_q [NV];

    // Field writes from the configuration port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NV; v++) begin
                gl_q[v]   <= '0;
                gr_q[v]   <= '0;
                step_q[v] <= '0;
                base_q[v] <= '0;
            end
        end else if (wr_en && (int'(wr_voice) < NV)) begin
            case (cfg_field_e'(wr_field))
                FLD_GAIN_L: gl_q[wr_voice]   <= wr_data;
                FLD_GAIN_R: gr_q[wr_voice]   <= wr_data;
                FLD_STEP:   step_q[wr_voice] <= wr_data;
                default:    base_q[wr_voice] <= wr_data;
            endcase
        end
    end

    // Read mux for the voice being sequenced.
    always_comb begin
        rd_gain_l = gl_q[rd_voice];
        rd_gain_r = gr_q[rd_voice];
        rd_step   = step_q[rd_voice];
    end

    // Start addresses of every voice for simultaneous keying.
    for (genvar v = 0; v < NV; v++) begin : g_base
        assign base_all[v] = base_q[v];
    end
endmodule

// File: rtl/vm_voice_state.sv
// Per-voice playback state: position, block address, loop address, active
// and first-fetch flags. The sequencer rewrites the selected voice; a key-on
// overrides that write for any keyed voice in the same cycle.
// Assumes the RAM size is a power of two (2^AW halfwords).
module vm_voice_state #(
    parameter int NV    = 24,
    parameter int VIW   = 5,
    parameter int POS_W = 18,
    parameter int AW    = 18,
    parameter int LIM   = 28 << 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                key_stb,
    input  logic [NV-1:0]       key_mask,
    input  logic [NV-1:0][15:0] base_all,
    input  logic [VIW-1:0]      sel,
    output logic [POS_W-1:0]    cur_pos,
    output logic [AW-1:0]       cur_ba,
    output logic [AW-1:0]       cur_loop,
    output logic                cur_act,
    output logic                cur_fresh,
    input  logic                upd_en,
    input  logic [POS_W-1:0]    upd_pos,
    input  logic [AW-1:0]       upd_ba,
    input  logic [AW-1:0]       upd_loop,
    input  logic                upd_act,
    input  logic                upd_fresh
);
    logic [POS_W-1:0] pos_q   [NV];
    logic [AW-1:0]    ba_q    [NV];
    logic [AW-1:0]    loop_q  [NV];
    logic [NV-1:0]    act_q;
    logic [NV-1:0]    fresh_q;

    // Sequencer update of the selected voice, then key-on overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NV; v++) begin
                pos_q[v]  <= '0;
                ba_q[v]   <= '0;
                loop_q[v] <= '0;
            end
            act_q   <= '0;
            fresh_q <= '0;
        end else begin
            if (upd_en) begin
                pos_q[sel]   <= upd_pos;
                ba_q[sel]    <= upd_ba;
                loop_q[sel]  <= upd_loop;
                act_q[sel]   <= upd_act;
                fresh_q[sel] <= upd_fresh;
            end
            for (int v = 0; v < NV; v++) begin
                if (key_stb && key_mask[v]) begin
                    pos_q[v]   <= POS_W'(LIM);
                    ba_q[v]    <= AW'({base_all[v], 2'b00});
                    act_q[v]   <= 1'b1;
                    fresh_q[v] <= 1'b1;
                end
            end
        end
    end

    // Read-out of the sequenced voice.
    always_comb begin
        cur_pos   = pos_q[sel];
        cur_ba    = ba_q[sel];
        cur_loop  = loop_q[sel];
        cur_act   = act_q[sel];
        cur_fresh = fresh_q[sel];
    end

    for (genvar v = 0; v < NV; v++) begin : g_key_chk
        // R4
        keyon_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (key_stb && key_mask[v]) |=> (act_q[v] && fresh_q[v] && pos_q[v] == POS_W'(LIM)));
    end
endmodule

// File: rtl/voice_step_mixer.sv
// Voice pitch stepper and stereo mixer. On sample_start, visits the voices
// in order; a voice whose position has left the decoded block is refilled
// through the decoder handshake (loop/end flags applied), then its sample is
// scaled into the saturating left/right sums and its position stepped.
// Assumes the decoder holds samp_data for (samp_voice, samp_idx) during a
// mix cycle and that the pitch word never exceeds one block length.
module voice_step_mixer
    import vm_pkg::*;
#(
    parameter int NUM_VOICES = 24,
    parameter int BLOCK_LEN  = 28,
    parameter int FRAC_BITS  = 12,
    parameter int RAM_AW     = 18
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [$clog2(NUM_VOICES)-1:0]  cfg_voice,
    input  logic [1:0]                     cfg_field,
    input  logic [15:0]                    cfg_data,
    input  logic                           key_stb,
    input  logic [NUM_VOICES-1:0]          key_mask,
    input  logic                           irq_en,
    input  logic [15:0]                    irq_addr,
    input  logic                           sample_start,
    output logic                           fetch_req,
    output logic [$clog2(NUM_VOICES)-1:0]  fetch_voice,
    output logic [RAM_AW-1:0]              fetch_addr,
    output logic                           fetch_first,
    input  logic                           fetch_done,
    input  logic [7:0]                     fetch_flags,
    output logic [$clog2(NUM_VOICES)-1:0]  samp_voice,
    output logic [$clog2(BLOCK_LEN)-1:0]   samp_idx,
    input  logic signed [15:0]             samp_data,
    output logic signed [15:0]             out_l,
    output logic signed [15:0]             out_r,
    output logic                           sample_valid,
    output logic                           irq_hit
);
    localparam int VIW      = $clog2(NUM_VOICES);
    localparam int IDX_W    = $clog2(BLOCK_LEN);
    localparam int LIM      = BLOCK_LEN << FRAC_BITS;
    localparam int POS_W    = $clog2(LIM) + 1;
    localparam int BLOCK_HW = 1 + BLOCK_LEN / 4;
    localparam int IRW      = ((RAM_AW > 18) ? RAM_AW : 18) + 1;

    seq_state_e            state_q;
    logic [VIW-1:0]        vcur_q;
    logic signed [15:0]    acc_q  [2];
    logic signed [15:0]    mix_d  [2];
    logic signed [15:0]    out_q  [2];
    logic [15:0]           vol_w  [2];

    logic [15:0]           gain_l, gain_r, step;
    logic [NUM_VOICES-1:0][15:0] base_all;
    logic [POS_W-1:0]      cur_pos, upd_pos;
    logic [RAM_AW-1:0]     cur_ba, cur_loop, upd_ba, upd_loop;
    logic                  cur_act, cur_fresh, upd_act, upd_fresh, upd_en;
    logic                  pos_over, irq_match, last_voice;
    logic [IRW-1:0]        watch_a, win_lo, win_hi;

    vm_voice_cfg #(.NV(NUM_VOICES), .VIW(VIW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_voice  (cfg_voice),
        .wr_field  (cfg_field),
        .wr_data   (cfg_data),
        .rd_voice  (vcur_q),
        .rd_gain_l (gain_l),
        .rd_gain_r (gain_r),
        .rd_step   (step),
        .base_all  (base_all)
    );

    vm_voice_state #(
        .NV(NUM_VOICES), .VIW(VIW), .POS_W(POS_W), .AW(RAM_AW), .LIM(LIM)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_stb   (key_stb),
        .key_mask  (key_mask),
        .base_all  (base_all),
        .sel       (vcur_q),
        .cur_pos   (cur_pos),
        .cur_ba    (cur_ba),
        .cur_loop  (cur_loop),
        .cur_act   (cur_act),
        .cur_fresh (cur_fresh),
        .upd_en    (upd_en),
        .upd_pos   (upd_pos),
        .upd_ba    (upd_ba),
        .upd_loop  (upd_loop),
        .upd_act   (upd_act),
        .upd_fresh (upd_fresh)
    );

    assign vol_w[0] = gain_l;
    assign vol_w[1] = gain_r;

    for (genvar ch = 0; ch < 2; ch++) begin : g_lane
        vm_mix_lane u_lane (
            .vol_word (vol_w[ch]),
            .sample   (samp_data),
            .acc_in   (acc_q[ch]),
            .acc_out  (mix_d[ch])
        );
    end

    // Refill need and the watched-address window of the current block.
    always_comb begin
        pos_over   = cur_pos >= POS_W'(LIM);
        last_voice = vcur_q == VIW'(NUM_VOICES - 1);
        watch_a    = IRW'({irq_addr, 2'b00});
        win_lo     = IRW'(cur_ba);
        win_hi     = win_lo + IRW'(BLOCK_HW - 1);
        irq_match  = irq_en && (watch_a >= win_lo) && (watch_a <= win_hi);
    end

    // Next state of the sequenced voice after a refill or a mix step.
    always_comb begin
        upd_en    = 1'b0;
        upd_pos   = cur_pos;
        upd_ba    = cur_ba;
        upd_loop  = cur_loop;
        upd_act   = cur_act;
        upd_fresh = cur_fresh;
        if (state_q == ST_FETCH && fetch_done) begin
            upd_en    = 1'b1;
            upd_fresh = 1'b0;
            upd_loop  = fetch_flags[2] ? cur_ba : cur_loop;
            upd_ba    = cur_ba + RAM_AW'(BLOCK_HW);
            if (fetch_flags[0]) begin
                if (fetch_flags == 8'd3) begin
                    upd_ba = upd_loop;
                end else begin
                    upd_act = 1'b0;
                end
            end
            upd_pos = cur_pos - POS_W'(LIM);
        end else if (state_q == ST_MIX) begin
            upd_en  = 1'b1;
            upd_pos = cur_pos + POS_W'(step);
        end
    end

    // Voice sequencer, accumulators and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            vcur_q       <= '0;
            acc_q[0]     <= '0;
            acc_q[1]     <= '0;
            out_q[0]     <= '0;
            out_q[1]     <= '0;
            sample_valid <= 1'b0;
            irq_hit      <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            irq_hit      <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (sample_start) begin
                        acc_q[0] <= '0;
                        acc_q[1] <= '0;
                        vcur_q   <= '0;
                        state_q  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!pos_over) begin
                        state_q <= ST_MIX;
                    end else if (cur_act) begin
                        state_q <= ST_FETCH;
                        irq_hit <= irq_match;
                    end else if (last_voice) begin
                        out_q[0]     <= acc_q[0];
                        out_q[1]     <= acc_q[1];
                        sample_valid <= 1'b1;
                        state_q      <= ST_IDLE;
                    end else begin
                        vcur_q <= vcur_q + 1'b1;
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) begin
                        state_q <= ST_MIX;
                    end
                end
                default: begin
                    acc_q[0] <= mix_d[0];
                    acc_q[1] <= mix_d[1];
                    if (last_voice) begin
                        out_q[0]     <= mix_d[0];
                        out_q[1]     <= mix_d[1];
                        sample_valid <= 1'b1;
                        state_q      <= ST_IDLE;
                    end else begin
                        vcur_q  <= vcur_q + 1'b1;
                        state_q <= ST_CHECK;
                    end
                end
            endcase
        end
    end

    // Decoder-facing outputs.
    always_comb begin
        fetch_req   = state_q == ST_FETCH;
        fetch_voice = vcur_q;
        fetch_addr  = cur_ba;
        fetch_first = cur_fresh;
        samp_voice  = vcur_q;
        samp_idx    = cur_pos[FRAC_BITS +: IDX_W];
        out_l       = out_q[0];
        out_r       = out_q[1];
    end

    // R3
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_done && !key_stb) |=> (fetch_req && $stable(fetch_addr)));
    // R3
    refill_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && fetch_done && !key_stb) |=> (cur_pos < POS_W'(LIM)));
    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MIX) |-> (int'(samp_idx) < BLOCK_LEN));
    // R6
    fetch_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> cur_act);
    // R7
    irq_with_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hit |-> fetch_req);
    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);
endmodule

// File: tb/voice_step_mixer_tb.sv
module voice_step_mixer_tb;
    localparam int NV  = 24;
    localparam int LIM = 28 << 12;
    localparam int RAM = 1 << 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_voice = '0;
    logic [1:0]  cfg_field = '0;
    logic [15:0] cfg_data = '0;
    logic        key_stb = 1'b0;
    logic [23:0] key_mask = '0;
    logic        irq_en = 1'b0;
    logic [15:0] irq_addr = '0;
    logic        sample_start = 1'b0;
    logic        fetch_req, fetch_first, fetch_done = 1'b0;
    logic [4:0]  fetch_voice, samp_voice, samp_idx;
    logic [17:0] fetch_addr;
    logic [7:0]  fetch_flags = '0;
    logic signed [15:0] samp_data = '0;
    logic signed [15:0] out_l, out_r;
    logic        sample_valid, irq_hit;

    always #2 clk = ~clk;

    voice_step_mixer u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_voice(cfg_voice), .cfg_field(cfg_field), .cfg_data(cfg_data),
        .key_stb(key_stb), .key_mask(key_mask),
        .irq_en(irq_en), .irq_addr(irq_addr), .sample_start(sample_start),
        .fetch_req(fetch_req), .fetch_voice(fetch_voice), .fetch_addr(fetch_addr),
        .fetch_first(fetch_first), .fetch_done(fetch_done), .fetch_flags(fetch_flags),
        .samp_voice(samp_voice), .samp_idx(samp_idx), .samp_data(samp_data),
        .out_l(out_l), .out_r(out_r), .sample_valid(sample_valid), .irq_hit(irq_hit)
    );

    int n_checks = 0;
    int n_fails  = 0;

    // Reference model state, driven only from the requirements.
    int m_pos [NV];
    int m_ba  [NV];
    int m_loop[NV];
    int m_act [NV];
    int m_cur [NV];
    int m_gl  [NV];
    int m_gr  [NV];
    int m_step[NV];
    int m_base[NV];
    int m_irq_en = 0;
    int m_irq_addr = 0;
    int flag_map [int];
    int smp_mode = 0;

    // Bench decoder state.
    int dcur [NV];
    bit need_first [NV];
    int fwait = 0;
    int irq_cnt = 0;

    // Scoreboard queues.
    int    ql[$];
    int    qr[$];
    int    qi[$];
    string qt[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int gain_of(input int w);
        if ((w & 'h8000) != 0) return (w & 'h7F) * 128;
        if ((w & 'h4000) != 0) return -(w & 'h3FFF);
        return w;
    endfunction

    function automatic int smp_of(input int addr, input int idx);
        int x;
        if (smp_mode == 1) return 30000;
        if (smp_mode == 2) return -30000;
        x = (addr * 97 + idx * 1231 + 17) & 'hFFFF;
        return (x >= 32768) ? x - 65536 : x;
    endfunction

    function automatic int sat(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int flags_of(input int addr);
        if (flag_map.exists(addr)) return flag_map[addr];
        return 0;
    endfunction

    // One output sample of the model: refill, flags, IRQ, mix, step.
    task automatic model_sample(output int el, output int er, output int ei);
        int f;
        int s;
        el = 0; er = 0; ei = 0;
        for (int v = 0; v < NV; v++) begin
            if (m_pos[v] >= LIM) begin
                if (m_act[v] == 0) continue;
                if (m_irq_en != 0 && m_irq_addr * 4 >= m_ba[v] && m_irq_addr * 4 <= m_ba[v] + 7) ei++;
                f = flags_of(m_ba[v]);
                m_cur[v] = m_ba[v];
                if ((f & 4) != 0) m_loop[v] = m_ba[v];
                m_ba[v] = (m_ba[v] + 8) % RAM;
                if ((f & 1) != 0) begin
                    if (f == 3) m_ba[v] = m_loop[v];
                    else m_act[v] = 0;
                end
                m_pos[v] = m_pos[v] - LIM;
            end
            s = smp_of(m_cur[v], m_pos[v] >> 12);
            el = sat(el + (s * gain_of(m_gl[v])) / 16384);
            er = sat(er + (s * gain_of(m_gr[v])) / 16384);
            m_pos[v] = m_pos[v] + m_step[v];
        end
    endtask

    task automatic cfg(input int v, input int fld, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_voice = 5'(v); cfg_field = 2'(fld); cfg_data = 16'(d);
        case (fld)
            0: m_gl[v] = d;
            1: m_gr[v] = d;
            2: m_step[v] = d;
            default: m_base[v] = d;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic keyon(input logic [23:0] m);
        @(negedge clk);
        key_stb = 1'b1; key_mask = m;
        for (int v = 0; v < NV; v++) begin
            if (m[v]) begin
                m_pos[v] = LIM;
                m_ba[v]  = (m_base[v] * 4) % RAM;
                m_act[v] = 1;
                need_first[v] = 1'b1;
            end
        end
        @(negedge clk);
        key_stb = 1'b0; key_mask = '0;
    endtask

    task automatic set_irq(input int en, input int a);
        @(negedge clk);
        irq_en = en[0]; irq_addr = 16'(a);
        m_irq_en = en; m_irq_addr = a;
    endtask

    // Driver: predict, push, start the period and wait for its result.
    task automatic run(input int n, input string tag);
        int el, er, ei;
        for (int k = 0; k < n; k++) begin
            model_sample(el, er, ei);
            ql.push_back(el); qr.push_back(er); qi.push_back(ei); qt.push_back(tag);
            @(negedge clk);
            sample_start = 1'b1;
            @(negedge clk);
            sample_start = 1'b0;
            while (!sample_valid) @(negedge clk);
            @(negedge clk);
        end
    endtask

    // Bench decoder: answers fetches after a short delay, serves samples.
    always @(negedge clk) begin
        if (!rst_n) begin
            fetch_done = 1'b0;
            fwait = 0;
        end else if (fetch_req && !fetch_done) begin
            if (fwait == 2) begin
                fetch_done  = 1'b1;
                fetch_flags = 8'(flags_of(int'(fetch_addr)));
                dcur[fetch_voice] = int'(fetch_addr);
                // R4: history clear requested only on the first fetch after key-on
                check(fetch_first == need_first[fetch_voice], "R4 fetch_first",
                      int'(fetch_first), int'(need_first[fetch_voice]));
                need_first[fetch_voice] = 1'b0;
                fwait = 0;
            end else begin
                fwait++;
            end
        end else begin
            fetch_done = 1'b0;
        end
        samp_data = 16'(smp_of(dcur[samp_voice], int'(samp_idx)));
    end

    // Monitor: counts interrupt pulses, pops and compares each result.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_hit) irq_cnt++;
            if (sample_valid) begin
                if (ql.size() == 0) begin
                    check(1'b0, "R10 unexpected sample_valid", 1, 0);
                end else begin
                    int el, er, ei;
                    string t;
                    el = ql.pop_front(); er = qr.pop_front(); ei = qi.pop_front(); t = qt.pop_front();
                    check(int'(out_l) == el, {t, " left"}, int'(out_l), el);
                    check(int'(out_r) == er, {t, " right"}, int'(out_r), er);
                    check(irq_cnt == ei, {t, " R7 irq count"}, irq_cnt, ei);
                end
                irq_cnt = 0;
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int v = 0; v < NV; v++) begin
            m_pos[v] = 0; m_ba[v] = 0; m_loop[v] = 0; m_act[v] = 0; m_cur[v] = 0;
            m_gl[v] = 0; m_gr[v] = 0; m_step[v] = 0; m_base[v] = 0;
            dcur[v] = 0; need_first[v] = 1'b0;
        end
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        check(out_l == 0, "R1 out_l", int'(out_l), 0);
        check(out_r == 0, "R1 out_r", int'(out_r), 0);
        check(sample_valid == 0, "R1 sample_valid", int'(sample_valid), 0);
        check(fetch_req == 0, "R1 fetch_req", int'(fetch_req), 0);
        check(irq_hit == 0, "R1 irq_hit", int'(irq_hit), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R6: nothing keyed, silence and no fetch
        run(2, "R1 idle");

        // R2 R3 R4 R8: integer pitch, raw and bit-15 gains, block crossings
        cfg(0, 0, 'h3FFF); cfg(0, 1, 'h80FF); cfg(0, 2, 'h1000); cfg(0, 3, 'h0010);
        keyon(24'h000001);
        run(40, "R2 R3 R8 integer pitch");

        // R6 R8: fractional pitch, bit-14 negative gain, end flag on 2nd block
        flag_map[32'h408] = 1;
        cfg(1, 0, 'h6000); cfg(1, 1, 'hC010); cfg(1, 2, 'h2800); cfg(1, 3, 'h0100);
        keyon(24'h000002);
        run(40, "R6 end flag");

        // R5 R6 R7: loop start, loop back with flags 3, watched address in a block
        flag_map[32'h800] = 4;
        flag_map[32'h810] = 3;
        set_irq(1, 'h203);
        cfg(2, 0, 'h2000); cfg(2, 1, 'h1000); cfg(2, 2, 'h4000); cfg(2, 3, 'h0200);
        keyon(24'h000004);
        run(30, "R5 R7 loop");
        set_irq(0, 'h203);
        run(10, "R7 irq disabled");
        set_irq(1, 'h204);
        run(10, "R7 window edge");
        set_irq(0, 0);

        // R3 R4: start at top of RAM, maximum pitch, address wrap
        cfg(3, 0, 'h2000); cfg(3, 1, 'h3000); cfg(3, 2, 'hFFFF); cfg(3, 3, 'hFFFF);
        keyon(24'h000008);
        run(20, "R3 wrap max pitch");

        // R4: retrigger voice 0 mid-block
        keyon(24'h000001);
        run(6, "R4 retrigger");

        // R9: per-addition clamp with positive then negative voices
        for (int v = 4; v < 10; v++) begin
            cfg(v, 0, (v < 8) ? 'h3FFF : 'h7FFF);
            cfg(v, 1, 'h3FFF);
            cfg(v, 2, 'h1000);
            cfg(v, 3, 'h1000 + v * 8);
        end
        keyon(24'h0003F0);
        smp_mode = 1;
        run(4, "R9 clamp positive");
        smp_mode = 2;
        run(4, "R9 clamp negative");
        smp_mode = 0;
        run(4, "R9 mixed");

        repeat (4) @(negedge clk);
        check(ql.size() == 0, "R10 pending results", ql.size(), 0);
        finish_run();
    end
endmodule